// File: doc/BRIEF.md
# I2C Register File Slave

This block connects an I2C bus to a register file of 64 bytes. A fast system clock samples SCL and SDA. The block detects START, repeated START and STOP, and matches the 7-bit device address. It acknowledges the bytes it accepts. On a write, the received data leaves through a parallel port to the register file. On a read, the register contents are shifted back out on SDA. SDA is open-drain: the block raises `sda_oe` only when it pulls the line low.

There are two addressing modes, selected by an auto-increment control bit held in the register file. With the bit clear, every data byte needs its own register address byte. A read then returns exactly one byte for each device-address byte. With the bit set, one address byte starts a run of consecutive registers. The run stops at the last register, 0x3F. After that, the next written byte is taken as a fresh starting address.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset, `sda_oe` and `reg_we` are low and auto-increment is off.
- R2: A device byte whose top 7 bits equal `DEV_ADDR` is acknowledged on the ninth clock, with bit 0 as R/W (1 = read). On a mismatch the block gives no acknowledge, ignores every byte up to the next START or STOP, and writes nothing.
- R3: START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high) are recognised in any state. A repeated START makes the next byte a device byte again, and the block releases SDA after either condition.
- R4: The low 6 bits of a register address byte select the register. The top 2 bits are ignored.
- R5: With auto-increment off, a write alternates between an address byte and a data byte. Each data byte causes exactly one single-cycle `reg_we` pulse to the address last sent.
- R6: With auto-increment on, the data bytes after one address byte go to consecutive registers. After a byte is written to 0x3F, the next byte is acknowledged as a new starting address and is not written.
- R7: A repeated START or a STOP ends an auto-increment run. The first byte after the next device byte is again an address byte.
- R8: A read returns the addressed register MSB first. When the master does not acknowledge, the block releases SDA.
- R9: With auto-increment off, a read gives one data byte only. Any further byte reads as 0xFF, even after a master acknowledge.
- R10: With auto-increment on, a master acknowledge makes the block send the next register. After register 0x3F has been sent, further bytes read as 0xFF.
- R11: The auto-increment control is bit 5 of register 0x3E. The block takes it from writes to that register, and the new value applies from the next START or STOP.
- R12: Register address bytes and write data bytes are acknowledged. A write strobe occurs only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High to pull SDA low (open-drain) |
| reg_addr | output | ADDR_W | Register file address for writes and reads |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational |

## Verification
The assertions assume a well-formed master. SDA changes only while SCL is low, except when it forms START or STOP. Each SCL phase lasts several system clocks, so the synchronised edges arrive before the next level change. The bench master keeps ten system clocks per quarter bit and resolves SDA as a wired-AND of its own drive and `sda_oe`. It issues START, repeated START and STOP only while the slave has released the line.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RD,
        ST_RD_ACK
    } rs_state_e;

    // Conditioned bus events produced by the sampler.
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic is_ack_state(rs_state_e s);
        return (s == ST_DEV_ACK) || (s == ST_REG_ACK) || (s == ST_WR_ACK);
    endfunction

    function automatic logic is_rx_state(rs_state_e s);
        return (s == ST_DEV) || (s == ST_REG) || (s == ST_WR);
    endfunction

endpackage

// File: rtl/i2c_rs_bus_sync.sv
module i2c_rs_bus_sync
    import i2c_rs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_lvl,
    output bus_ev_t ev
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_q, sda_q;
    logic         scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[MSB-1:0], scl_i};
            sda_q <= {sda_q[MSB-1:0], sda_i};
            scl_d <= scl_q[MSB];
            sda_d <= sda_q[MSB];
        end
    end

    assign scl_lvl     = scl_q[MSB];
    assign ev.sda      = sda_q[MSB];
    assign ev.scl_rise = scl_q[MSB] & ~scl_d;
    assign ev.scl_fall = ~scl_q[MSB] & scl_d;
    assign ev.start    = scl_q[MSB] & scl_d & sda_d & ~sda_q[MSB];
    assign ev.stop     = scl_q[MSB] & scl_d & ~sda_d & sda_q[MSB];

endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h3B,
    parameter int         ADDR_W    = 6,
    parameter int         AI_BIT    = 5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h3E
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              sda_oe
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [CNT_W-1:0]  FULL      = CNT_W'(BYTE_W);

    rs_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [ADDR_W-1:0] ptr;
    logic              rw, mack, ai_shadow, ai_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            sh        <= '1;
            ptr       <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            ai_shadow <= 1'b0;
            ai_active <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (ev.start) begin
                state     <= ST_DEV;
                cnt       <= '0;
                ai_active <= ai_shadow;
            end else if (ev.stop) begin
                state     <= ST_IDLE;
                ai_active <= ai_shadow;
            end else begin
                case (state)
                    ST_DEV, ST_REG, ST_WR: begin
                        if (ev.scl_rise && cnt < FULL) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_DEV) begin
                                if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                                    rw    <= sh[0];
                                    state <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_REG) begin
                                ptr   <= sh[ADDR_W-1:0];
                                state <= ST_REG_ACK;
                            end else begin
                                reg_we    <= 1'b1;
                                reg_wdata <= sh;
                                if (ptr == CTRL_ADDR) ai_shadow <= sh[AI_BIT];
                                state <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: if (ev.scl_fall) state <= rw ? ST_RD_LOAD : ST_REG;
                    ST_REG_ACK: if (ev.scl_fall) state <= ST_WR;
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            if (ai_active && ptr != LAST_ADDR) begin
                                ptr   <= ptr + 1'b1;
                                state <= ST_WR;
                            end else begin
                                state <= ST_REG;
                            end
                        end
                    end
                    ST_RD_LOAD: begin
                        sh    <= reg_rdata;
                        cnt   <= '0;
                        state <= ST_RD;
                    end
                    ST_RD: begin
                        if (ev.scl_fall) begin
                            sh  <= {sh[BYTE_W-2:0], 1'b1};
                            cnt <= cnt + 1'b1;
                            if (cnt == FULL - 1'b1) state <= ST_RD_ACK;
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) mack <= ~ev.sda;
                        if (ev.scl_fall) begin
                            if (mack && ai_active && ptr != LAST_ADDR) begin
                                ptr   <= ptr + 1'b1;
                                state <= ST_RD_LOAD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reg_addr = ptr;
    assign sda_oe   = is_ack_state(state) || (state == ST_RD && !sh[BYTE_W-1]);

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h3B,
    parameter int         ADDR_W      = 6,
    parameter int         SYNC_STAGES = 2,
    parameter int         AI_BIT      = 5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h3E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    input  logic [7:0]        reg_rdata
);
    bus_ev_t bus_ev;
    logic    scl_s, start_det, stop_det;

    i2c_rs_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_s),
        .ev      (bus_ev)
    );

    i2c_rs_engine #(
        .DEV_ADDR  (DEV_ADDR),
        .ADDR_W    (ADDR_W),
        .AI_BIT    (AI_BIT),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev        (bus_ev),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .sda_oe    (sda_oe)
    );

    assign start_det = bus_ev.start;
    assign stop_det  = bus_ev.stop;

endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic reg_we
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sda_oe && !reg_we));

    assert_oe_moves_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    assert_release_after_start_R3: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

    assert_release_after_stop_R3: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    assert_we_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    assert_we_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !scl_s);
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we)
);

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;
    localparam logic [6:0] DEV = 7'h3B;
    localparam logic [7:0] DW  = {DEV, 1'b0};
    localparam logic [7:0] DR  = {DEV, 1'b1};
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic       sda_bus;
    logic       sda_oe, reg_we;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] regs [64];

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [13:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    assign sda_bus = msda & ~sda_oe;

    i2c_regfile_slave #(.DEV_ADDR(DEV)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    // Register file neighbour
    assign reg_rdata = regs[reg_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) regs[i] <= 8'h00;
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Reference model: every write strobe is compared against the expected stream
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected write", {18'd0, reg_addr, reg_wdata}, 32'hFFFF);
            end else begin
                chk(tag_q.pop_front(), {18'd0, reg_addr, reg_wdata}, {18'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic push_w(logic [5:0] a, logic [7:0] d, string req);
        exp_q.push_back({a, d});
        tag_q.push_back(req);
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        msda = 1'b1; scl = 1'b1; wq();
        msda = 1'b0; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        msda = 1'b1; wq();
        scl = 1'b1; wq();
        msda = 1'b0; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        msda = 1'b0; wq();
        scl = 1'b1; wq();
        msda = 1'b1; wq();
    endtask

    task automatic wbyte(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; wq();
            scl = 1'b1; wq(); wq();
            scl = 1'b0; wq();
        end
        msda = 1'b1; wq();
        scl = 1'b1; wq();
        ack = ~sda_bus; wq();
        scl = 1'b0; wq();
    endtask

    task automatic rbyte(logic give_ack, output logic [7:0] b);
        msda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl = 1'b1; wq();
            b[i] = sda_bus; wq();
            scl = 1'b0;
        end
        wq();
        msda = ~give_ack; wq();
        scl = 1'b1; wq(); wq();
        scl = 1'b0; wq();
        msda = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        logic       a;
        logic [7:0] b;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        wq();
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 reg_we", reg_we, 0);

        // R2: foreign device address is ignored
        bus_start();
        wbyte({7'h12, 1'b0}, a); chk("R2 mismatch nack", a, 0);
        wbyte(8'h05, a);         chk("R2 ignored byte", a, 0);
        wbyte(8'h99, a);         chk("R2 ignored data", a, 0);
        bus_stop();

        // R4, R5, R12: alternating writes, upper address bits dropped
        bus_start();
        wbyte(DW, a);    chk("R2 match ack", a, 1);
        wbyte(8'hC5, a); chk("R12 addr ack", a, 1);
        push_w(6'h05, 8'hA5, "R4");
        wbyte(8'hA5, a); chk("R12 data ack", a, 1);
        wbyte(8'h10, a); chk("R5 second addr ack", a, 1);
        push_w(6'h10, 8'h3C, "R5");
        wbyte(8'h3C, a);
        bus_stop();
        chk("R5 writes done", exp_q.size(), 0);

        // R8: single read then nack and release
        bus_start();
        wbyte(DW, a); wbyte(8'h05, a);
        bus_rstart();
        wbyte(DR, a); chk("R3 dev after rstart", a, 1);
        rbyte(1'b0, b); chk("R8 read data", b, 8'hA5);
        chk("R8 released", sda_oe, 0);
        bus_stop();

        // R9: no second byte without auto-increment
        bus_start();
        wbyte(DW, a); wbyte(8'h10, a);
        bus_rstart();
        wbyte(DR, a);
        rbyte(1'b1, b); chk("R8 read second reg", b, 8'h3C);
        rbyte(1'b0, b); chk("R9 no extra byte", b, 8'hFF);
        bus_stop();

        // R11: enable auto-increment via register 0x3E bit 5
        bus_start();
        wbyte(DW, a); wbyte(8'h3E, a);
        push_w(6'h3E, 8'h20, "R11");
        wbyte(8'h20, a);
        bus_stop();

        // R6: consecutive writes, stop at 0x3F, new start address
        bus_start();
        wbyte(DW, a); wbyte(8'h3C, a);
        push_w(6'h3C, 8'h11, "R6"); wbyte(8'h11, a);
        push_w(6'h3D, 8'h22, "R6"); wbyte(8'h22, a);
        push_w(6'h3E, 8'h33, "R6"); wbyte(8'h33, a);
        push_w(6'h3F, 8'h44, "R6"); wbyte(8'h44, a);
        wbyte(8'h08, a); chk("R6 new start ack", a, 1);
        push_w(6'h08, 8'h55, "R6"); wbyte(8'h55, a);
        bus_stop();
        chk("R6 writes done", exp_q.size(), 0);

        // R10: auto-increment read up to 0x3F
        bus_start();
        wbyte(DW, a); wbyte(8'h3D, a);
        bus_rstart();
        wbyte(DR, a);
        rbyte(1'b1, b); chk("R10 first", b, 8'h22);
        rbyte(1'b1, b); chk("R10 next", b, 8'h33);
        rbyte(1'b1, b); chk("R10 last reg", b, 8'h44);
        rbyte(1'b0, b); chk("R10 halt after 3F", b, 8'hFF);
        bus_stop();

        // R7: repeated START and STOP end a run
        bus_start();
        wbyte(DW, a); wbyte(8'h20, a);
        push_w(6'h20, 8'h01, "R7"); wbyte(8'h01, a);
        bus_rstart();
        wbyte(DW, a); wbyte(8'h30, a);
        push_w(6'h30, 8'h02, "R7"); wbyte(8'h02, a);
        bus_stop();
        bus_start();
        wbyte(DW, a); wbyte(8'h2A, a);
        push_w(6'h2A, 8'hBB, "R7"); wbyte(8'hBB, a);
        bus_stop();
        chk("R7 writes done", exp_q.size(), 0);

        // R11: clearing the bit takes effect only in the next transaction
        bus_start();
        wbyte(DW, a); wbyte(8'h3E, a);
        push_w(6'h3E, 8'h00, "R11"); wbyte(8'h00, a);
        push_w(6'h3F, 8'h77, "R11"); wbyte(8'h77, a);
        bus_stop();
        bus_start();
        wbyte(DW, a); wbyte(8'h01, a);
        push_w(6'h01, 8'h5A, "R11"); wbyte(8'h5A, a);
        wbyte(8'h02, a); chk("R11 alternating again", a, 1);
        push_w(6'h02, 8'h6B, "R11"); wbyte(8'h6B, a);
        bus_stop();
        chk("R11 writes done", exp_q.size(), 0);

        bus_start();
        wbyte(DW, a); wbyte(8'h3F, a);
        bus_rstart();
        wbyte(DR, a);
        rbyte(1'b1, b); chk("R11 readback 3F", b, 8'h77);
        rbyte(1'b0, b); chk("R9 single byte", b, 8'hFF);
        bus_stop();

        wq();
        done = 1;
        finish_run();
    end
endmodule